// File: doc/BRIEF.md
# Delayed Synaptic Input Accumulator

This block collects weighted synaptic events for a small group of neurons and releases them a chosen number of timesteps later. Each event names a target neuron, a signed weight, a signed graded spike value and a delay. The block multiplies the weight by the spike value. It adds the product into an accumulator that belongs to a future timestep. All accumulators sit in a 64-slot circular buffer held inside the block, and a current-slot pointer indexes that buffer modulo 64.

A global strobe ends each timestep. When the block accepts the strobe it streams the current slot out, one signed sum per neuron in ascending index order. It clears each entry as it reads it and then moves the pointer forward by one slot. While this readout runs, the event input deasserts its ready, so the sender holds events back until the readout is over. The neuron update that consumes the sums lies outside this block.

Top module: `syn_delay_accum`

## Requirements
- R1: After reset, `ev_ready` is 1, `out_valid` is 0, `dly_err` is 0, and every accumulator holds 0.
- R2: An accepted event (`ev_valid` and `ev_ready` both 1 at a rising clock edge) adds the signed product `ev_weight * ev_spike` to the accumulator for neuron `ev_neuron`. Several events that reach the same neuron and slot add together. Events to different neurons do not affect each other.
- R3: Count strobe readouts from the moment an event is accepted. A strobe accepted in the same cycle as the event counts as the first readout. An event with delay d (d ≤ 62) first appears in readout number d+2. It never lands in the slot that is being read out.
- R4: A delay of 63 is treated as 62. Accepting such an event sets `dly_err` to 1, and it stays at 1 until reset.
- R5: Each accumulator is `ACC_W` bits wide. The sum saturates at +(2^(ACC_W-1))-1 and at -(2^(ACC_W-1)) instead of wrapping.
- R6: In the cycle after a strobe is accepted, the readout starts. It then drives `out_valid` = 1 for `N_NEURONS` consecutive cycles, with `out_neuron` running from 0 up to `N_NEURONS-1` and `out_sum` carrying that neuron's sum. Each entry reads back as 0 when its slot is next reused, unless new events have reached it.
- R7: `ev_ready` is 0 from the cycle after a strobe is accepted until the last sum has been read. A strobe that arrives during a readout is ignored. An event held through a readout is accepted afterwards and is scheduled from the advanced pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is offered |
| ev_ready | output | 1 | The block can accept an event |
| ev_neuron | input | $clog2(N_NEURONS) | Target neuron index |
| ev_weight | input | W_W | Signed synaptic weight |
| ev_spike | input | S_W | Signed graded spike value |
| ev_delay | input | 6 | Delay in timesteps; values above 62 are clamped |
| step_i | input | 1 | Timestep-advance strobe |
| out_valid | output | 1 | `out_neuron` and `out_sum` are valid |
| out_neuron | output | $clog2(N_NEURONS) | Neuron index of the current sum |
| out_sum | output | ACC_W | Signed sum delivered to the neuron |
| dly_err | output | 1 | Sticky flag set by a clamped delay |

## Verification
Two functions can fall in the same cycle: accepting an event and accepting a timestep strobe. The bench raises `ev_valid` and `step_i` on the same falling edge with a delay of 0. The readout that this strobe starts must not show the event. The next readout must show the event's exact product.

A second collision is a held event, together with an extra strobe pulse, arriving during a readout. The bench judges it by three observations: `ev_ready` stays low, no extra readout appears, and the event's sum comes out one slot later than it would have if accepted before the strobe.

// File: rtl/sda_pkg.sv
package sda_pkg;
  // Fixed buffer geometry: slot count and delay range are behaviour, not tuning
  localparam int SLOT_W    = 6;
  localparam int SLOT_CNT  = 1 << SLOT_W;
  localparam int DLY_W     = 6;
  localparam int MAX_DLY   = 62;

  // Limit a requested delay to the largest legal one
  function automatic logic [DLY_W-1:0] clamp_dly(input logic [DLY_W-1:0] d);
    return (d > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : d;
  endfunction

  // Slot that a delay lands in: one past the slot under readout, plus the delay
  function automatic logic [SLOT_W-1:0] land_slot(input logic [SLOT_W-1:0] cur,
                                                  input logic [DLY_W-1:0] d);
    return SLOT_W'(cur + SLOT_W'(1) + SLOT_W'(d));
  endfunction
endpackage

// File: rtl/sda_slot_calc.sv
module sda_slot_calc
  import sda_pkg::*;
(
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic [DLY_W-1:0]  delay_in,
  output logic [SLOT_W-1:0] tgt_slot,
  output logic              over_lim
);
  assign over_lim = (delay_in > DLY_W'(MAX_DLY));
  assign tgt_slot = land_slot(cur_slot, clamp_dly(delay_in));
endmodule

// File: rtl/sda_readout_ctl.sv
module sda_readout_ctl
  import sda_pkg::*;
#(
  parameter int N_NEURONS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         step_i,
  output logic                         busy,
  output logic [$clog2(N_NEURONS)-1:0] rd_idx,
  output logic [SLOT_W-1:0]            cur_slot
);
  localparam int NRN_W = $clog2(N_NEURONS);
  localparam logic [NRN_W-1:0] LAST = NRN_W'(N_NEURONS - 1);

  logic rd_last;
  assign rd_last = busy && (rd_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rd_idx   <= '0;
      cur_slot <= '0;
    end else if (!busy) begin
      if (step_i) begin
        busy   <= 1'b1;
        rd_idx <= '0;
      end
    end else if (rd_last) begin
      busy     <= 1'b0;
      rd_idx   <= '0;
      cur_slot <= SLOT_W'(cur_slot + SLOT_W'(1));
    end else begin
      rd_idx <= NRN_W'(rd_idx + NRN_W'(1));
    end
  end

  // R6: pointer advances by exactly one when the last neuron is read
  a_r6_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> cur_slot == SLOT_W'($past(cur_slot) + SLOT_W'(1)))
    else $error("a_r6_ptr_advance");

  // R7: a strobe during readout neither restarts nor extends it
  a_r7_pointer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_last |=> $stable(cur_slot))
    else $error("a_r7_pointer_hold");
endmodule

// File: rtl/sda_acc_mem.sv
module sda_acc_mem
  import sda_pkg::*;
#(
  parameter int N_NEURONS = 8,
  parameter int W_W       = 8,
  parameter int S_W       = 8,
  parameter int ACC_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_en,
  input  logic [SLOT_W-1:0]            acc_slot,
  input  logic [$clog2(N_NEURONS)-1:0] acc_nrn,
  input  logic signed [W_W-1:0]        weight,
  input  logic signed [S_W-1:0]        spike,
  input  logic                         rd_en,
  input  logic [SLOT_W-1:0]            rd_slot,
  input  logic [$clog2(N_NEURONS)-1:0] rd_nrn,
  output logic signed [ACC_W-1:0]      rd_data
);
  localparam int PROD_W = W_W + S_W;
  localparam logic signed [ACC_W-1:0] SAT_HI = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {1'b1, {(ACC_W-1){1'b0}}};

  // Signed product at full width
  function automatic logic signed [PROD_W-1:0] mul_ws(input logic signed [W_W-1:0] w,
                                                      input logic signed [S_W-1:0] s);
    return PROD_W'(w) * PROD_W'(s);
  endfunction

  // Add with clipping to the accumulator range
  function automatic logic signed [ACC_W-1:0] sat_add(input logic signed [ACC_W-1:0] a,
                                                      input logic signed [PROD_W-1:0] p);
    logic [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {{(ACC_W+1-PROD_W){p[PROD_W-1]}}, p};
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? SAT_LO : SAT_HI;
    return s[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] acc_q [SLOT_CNT][N_NEURONS];
  logic signed [PROD_W-1:0] prod;
  assign prod = mul_ws(weight, spike);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      for (int s = 0; s < SLOT_CNT; s++)
        for (int n = 0; n < N_NEURONS; n++)
          acc_q[s][n] <= '0;
    end else begin
      if (rd_en) begin
        rd_data               <= acc_q[rd_slot][rd_nrn];
        acc_q[rd_slot][rd_nrn] <= '0;
      end
      if (acc_en)
        acc_q[acc_slot][acc_nrn] <= sat_add(acc_q[acc_slot][acc_nrn], prod);
    end
  end
endmodule

// File: rtl/syn_delay_accum.sv
module syn_delay_accum
  import sda_pkg::*;
#(
  parameter int N_NEURONS = 8,
  parameter int W_W       = 8,
  parameter int S_W       = 8,
  parameter int ACC_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_valid,
  output logic                         ev_ready,
  input  logic [$clog2(N_NEURONS)-1:0] ev_neuron,
  input  logic signed [W_W-1:0]        ev_weight,
  input  logic signed [S_W-1:0]        ev_spike,
  input  logic [DLY_W-1:0]             ev_delay,
  input  logic                         step_i,
  output logic                         out_valid,
  output logic [$clog2(N_NEURONS)-1:0] out_neuron,
  output logic signed [ACC_W-1:0]      out_sum,
  output logic                         dly_err
);
  localparam int NRN_W = $clog2(N_NEURONS);
  localparam logic [NRN_W-1:0] LAST = NRN_W'(N_NEURONS - 1);

  logic              busy;
  logic [NRN_W-1:0]  rd_idx;
  logic [SLOT_W-1:0] cur_slot;
  logic [SLOT_W-1:0] tgt_slot;
  logic              over_lim;
  logic              accept;

  assign ev_ready = !busy;
  assign accept   = ev_valid && ev_ready;

  sda_slot_calc u_calc (
    .cur_slot (cur_slot),
    .delay_in (ev_delay),
    .tgt_slot (tgt_slot),
    .over_lim (over_lim)
  );

  sda_readout_ctl #(.N_NEURONS(N_NEURONS)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step_i),
    .busy     (busy),
    .rd_idx   (rd_idx),
    .cur_slot (cur_slot)
  );

  sda_acc_mem #(
    .N_NEURONS (N_NEURONS),
    .W_W       (W_W),
    .S_W       (S_W),
    .ACC_W     (ACC_W)
  ) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (accept),
    .acc_slot (tgt_slot),
    .acc_nrn  (ev_neuron),
    .weight   (ev_weight),
    .spike    (ev_spike),
    .rd_en    (busy),
    .rd_slot  (cur_slot),
    .rd_nrn   (rd_idx),
    .rd_data  (out_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_neuron <= '0;
      dly_err    <= 1'b0;
    end else begin
      out_valid  <= busy;
      out_neuron <= rd_idx;
      if (accept && over_lim) dly_err <= 1'b1;
    end
  end

  // R3: an accepted event never targets the slot that is read next
  a_r3_not_current: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> tgt_slot != cur_slot)
    else $error("a_r3_not_current");

  // R4: an out-of-range delay raises the sticky flag
  a_r4_clamp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ev_delay > DLY_W'(MAX_DLY)) |=> dly_err)
    else $error("a_r4_clamp_flag");

  // R6: readout begins at neuron 0 and steps up by one
  a_r6_first_nrn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_neuron == '0)
    else $error("a_r6_first_nrn");

  a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> out_neuron == NRN_W'($past(out_neuron) + NRN_W'(1)))
    else $error("a_r6_order");

  // R7: no event is accepted while sums other than the last are streaming
  a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_neuron != LAST) |-> !ev_ready)
    else $error("a_r7_ready_low");
endmodule

// File: tb/syn_delay_accum_tb.sv
module syn_delay_accum_tb;
  localparam int N     = 8;
  localparam int ACC   = 16;
  localparam int SLOTS = 64;
  localparam longint HI = (longint'(1) <<< (ACC - 1)) - 1;
  localparam longint LO = -(longint'(1) <<< (ACC - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic ev_ready;
  logic [2:0] ev_neuron = '0;
  logic signed [7:0] ev_weight = '0;
  logic signed [7:0] ev_spike = '0;
  logic [5:0] ev_delay = '0;
  logic step_i = 1'b0;
  logic out_valid;
  logic [2:0] out_neuron;
  logic signed [ACC-1:0] out_sum;
  logic dly_err;

  int tests = 0;
  int fails = 0;
  longint mdl [SLOTS][N];
  int mcur = 0;

  always #5 clk = ~clk;

  syn_delay_accum u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_neuron(ev_neuron), .ev_weight(ev_weight), .ev_spike(ev_spike),
    .ev_delay(ev_delay), .step_i(step_i), .out_valid(out_valid),
    .out_neuron(out_neuron), .out_sum(out_sum), .dly_err(dly_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench-side scheduling: clip the delay, then clip the running sum
  task automatic model_add(input int n, input int w, input int s, input int d);
    int dd;
    int slot;
    longint v;
    dd = (d > 62) ? 62 : d;
    slot = (mcur + dd + 1) % SLOTS;
    v = mdl[slot][n] + longint'(w) * longint'(s);
    if (v > HI) v = HI;
    if (v < LO) v = LO;
    mdl[slot][n] = v;
  endtask

  task automatic drive_ev(input int n, input int w, input int s, input int d);
    ev_neuron = 3'(n);
    ev_weight = 8'(w);
    ev_spike  = 8'(s);
    ev_delay  = 6'(d);
    ev_valid  = 1'b1;
  endtask

  task automatic send_ev(input int n, input int w, input int s, input int d);
    @(negedge clk);
    drive_ev(n, w, s, d);
    while (!ev_ready) @(negedge clk);
    model_add(n, w, s, d);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // Called just after the strobe edge; samples each streamed sum
  task automatic collect(input string req);
    check(ev_ready == 1'b0, "R7 ready low in readout", longint'(ev_ready), 0);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, {req, " out_valid"}, longint'(out_valid), 1);
      check(int'(out_neuron) == k, "R6 neuron order", longint'(out_neuron), k);
      check(longint'(out_sum) == mdl[mcur][k], {req, " sum"}, longint'(out_sum), mdl[mcur][k]);
      mdl[mcur][k] = 0;
    end
    mcur = (mcur + 1) % SLOTS;
    check(ev_ready == 1'b1, "R7 ready back after readout", longint'(ev_ready), 1);
  endtask

  task automatic do_step(input string req);
    @(negedge clk);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    collect(req);
  endtask

  task automatic t_reset;
    check(ev_ready == 1'b1, "R1 ready", longint'(ev_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(dly_err == 1'b0, "R1 dly_err", longint'(dly_err), 0);
    do_step("R1 zero after reset");
  endtask

  task automatic t_basic;
    send_ev(0, 5, 3, 0);
    send_ev(2, -7, 4, 0);
    send_ev(0, 2, -1, 0);
    send_ev(5, 9, 9, 0);
    do_step("R3 delay0 absent in first readout");
    do_step("R2 products summed");
  endtask

  task automatic t_delay;
    send_ev(5, 11, -3, 3);
    send_ev(1, -20, -2, 1);
    for (int i = 0; i < 5; i++) do_step("R3 delay three");
  endtask

  task automatic t_concurrent;
    @(negedge clk);
    drive_ev(4, 13, 7, 0);
    step_i = 1'b1;
    model_add(4, 13, 7, 0);
    @(negedge clk);
    ev_valid = 1'b0;
    step_i = 1'b0;
    collect("R3 same-cycle event not in readout");
    do_step("R3 same-cycle event next readout");
  endtask

  task automatic t_busy;
    @(negedge clk);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    drive_ev(3, 6, 6, 0);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      check(out_sum == mdl[mcur][k], "R7 readout sum", longint'(out_sum), mdl[mcur][k]);
      mdl[mcur][k] = 0;
      if (k < N - 1) check(ev_ready == 1'b0, "R7 ready held low", longint'(ev_ready), 0);
      step_i = (k == 2);
    end
    mcur = (mcur + 1) % SLOTS;
    step_i = 1'b0;
    model_add(3, 6, 6, 0);
    @(negedge clk);
    ev_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 strobe in readout ignored", longint'(out_valid), 0);
    end
    do_step("R7 held event uses advanced pointer");
    do_step("R7 held event delivered");
  endtask

  task automatic t_sat;
    for (int i = 0; i < 3; i++) send_ev(1, 127, 127, 1);
    for (int i = 0; i < 3; i++) send_ev(6, -128, 127, 1);
    send_ev(2, 100, 100, 1);
    send_ev(2, -100, 100, 1);
    do_step("R5 saturation pending");
    do_step("R5 saturation pending");
    do_step("R5 clipped sums");
  endtask

  task automatic t_clamp;
    check(dly_err == 1'b0, "R4 flag clear before clamp", longint'(dly_err), 0);
    send_ev(6, 3, 5, 63);
    send_ev(7, -4, 5, 62);
    @(negedge clk);
    check(dly_err == 1'b1, "R4 flag set", longint'(dly_err), 1);
    for (int i = 0; i < 64; i++) do_step("R4 max delay and R6 cleared slots");
    check(dly_err == 1'b1, "R4 flag sticky", longint'(dly_err), 1);
  endtask

  initial begin
    for (int s = 0; s < SLOTS; s++)
      for (int n = 0; n < N; n++)
        mdl[s][n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_delay();
    t_concurrent();
    t_busy();
    t_sat();
    t_clamp();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule